// File: doc/BRIEF.md
# Dual H-Bridge Fault and Power-Mode Supervisor

This block decides, cycle by cycle, whether each of two H-bridges may switch, from the conditions reported by the analog side of a motor driver. It watches one current-limit flag per bridge, a die over-temperature flag and a supply undervoltage flag, together with an active-low reset pin and an active-low sleep pin. It drives one enable per bridge, an active-low fault indication, an internal logic-reset output and a ready flag.

Each fault recovers in its own way. A current-limit flag only counts once it has held for longer than a qualification window. It then latches a shutdown of that bridge that only a reset or a supply dip can clear. Over-temperature stops both bridges only for as long as it is present. Undervoltage clears the whole internal state, exactly like the reset pin. Leaving reset, undervoltage or sleep starts a wake-up delay before ready returns. Both the qualification window and the wake delay are clock-count parameters.

Top module: `hb_guard`

## Requirements
- R1: While `rst_n` is low: `logic_rst` is 1, `ready` is 0, `bridge_en` is all zero, `fault_n` is 1, and every latched shutdown is cleared.
- R2: A bridge's current-limit flag latches a shutdown only when it is sampled high on OC_QUAL+1 consecutive active cycles. Any active cycle with the flag low restarts the count, so a shorter pulse leaves no latch and no fault.
- R3: A latched shutdown forces that bridge's enable to 0 and `fault_n` to 0 from the cycle after the final qualifying sample. It leaves the other bridge enabled, and it persists after the flag drops until `rst_n` goes low or `uv_flag` goes high.
- R4: `ot_flag` sampled high while active drives `fault_n` to 0 and both enables to 0 in the next cycle. One cycle after it is sampled low, both return without any latch.
- R5: `uv_flag` high makes `logic_rst` 1 at once. From the next cycle it clears all latched shutdowns and the wake count, so `ready` is 0. Undervoltage alone never drives `fault_n` low.
- R6: While `sleep_n` is low, the next cycle shows `ready` 0 and all enables 0. Current-limit and temperature flags are ignored, and `fault_n` is 1 unless a latch is already set. A qualification count that is partly done is frozen and resumes on wake.
- R7: `ready` rises exactly WAKE_CYC cycles after the first cycle in which `rst_n` and `sleep_n` are high and `uv_flag` is low, with those levels held. It is 0 before that.
- R8: Bridge i is enabled exactly when `ready` is 1, no over-temperature is registered, and bridge i has no latched shutdown.
- R9: `fault_n` is 0 exactly when any latched shutdown is set or a registered over-temperature is present.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Supervisor clock |
| rst_n | input | 1 | Active-low reset pin, asynchronous clear of all state |
| sleep_n | input | 1 | Active-low sleep request |
| uv_flag | input | 1 | Supply undervoltage, high when below threshold |
| ot_flag | input | 1 | Die over-temperature, high when too hot |
| oc_flag | input | NBR | Per-bridge current-limit flag, bit i for bridge i |
| bridge_en | output | NBR | Per-bridge permission to switch, bit i for bridge i |
| fault_n | output | 1 | Active-low fault indication |
| logic_rst | output | 1 | High while the internal logic is held in reset |
| ready | output | 1 | High once the wake-up delay has elapsed |

## Verification
The hardest situation to reach from the ports is a qualification count that is interrupted by sleep and then completed after wake. The bench holds a current-limit flag for exactly OC_QUAL active samples and then enters sleep with the flag still high. It then wakes with the flag high for one more sample and expects the latch on that single cycle. A sweep over pulse lengths on each bridge, separated by one-cycle gaps, pins the qualification edge, and an undervoltage pulse applied over a live latch shows the full clear.

// File: rtl/hbg_pkg.sv
package hbg_pkg;

    // Operating condition shared by every sequential part of the supervisor.
    typedef enum logic [1:0] {
        MODE_HOLD   = 2'd0,   // undervoltage: internal state cleared
        MODE_SLEEP  = 2'd1,   // sleep requested: activity frozen
        MODE_ACTIVE = 2'd2    // normal operation
    } hbg_mode_e;

endpackage

// File: rtl/hbg_oc_qual.sv
module hbg_oc_qual
    import hbg_pkg::*;
#(
    parameter int OC_QUAL = 4
) (
    input  logic      clk,
    input  logic      rst_n,
    input  hbg_mode_e mode,
    input  logic      oc_flag,
    output logic      tripped
);
    localparam int CW = $clog2(OC_QUAL + 1);
    localparam logic [CW-1:0] QUAL_C = CW'(OC_QUAL);

    typedef struct packed {
        logic [CW-1:0] cnt;
        logic          trip;
    } qual_st_t;

    qual_st_t st_d, st_q;

    always_comb begin
        st_d = st_q;
        case (mode)
            MODE_HOLD:  st_d = '0;
            MODE_SLEEP: st_d = st_q;
            default: begin
                if (!st_q.trip) begin
                    if (oc_flag) begin
                        if (st_q.cnt == QUAL_C) begin
                            st_d.trip = 1'b1;
                        end else begin
                            st_d.cnt = st_q.cnt + 1'b1;
                        end
                    end else begin
                        st_d.cnt = '0;
                    end
                end
            end
        endcase
    end

    always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n) begin
            st_q <= '0;
        end else begin
            st_q <= st_d;
        end
    end

    assign tripped = st_q.trip;

endmodule

// File: rtl/hbg_wake_timer.sv
module hbg_wake_timer
    import hbg_pkg::*;
#(
    parameter int WAKE_CYC = 50000
) (
    input  logic      clk,
    input  logic      rst_n,
    input  hbg_mode_e mode,
    output logic      ready_o
);
    localparam int WW = $clog2(WAKE_CYC + 1);
    localparam logic [WW-1:0] WAKE_C = WW'(WAKE_CYC);

    typedef struct packed {
        logic [WW-1:0] cnt;
    } wake_st_t;

    wake_st_t st_d, st_q;

    always_comb begin
        st_d = st_q;
        if (mode != MODE_ACTIVE) begin
            st_d.cnt = '0;
        end else if (st_q.cnt != WAKE_C) begin
            st_d.cnt = st_q.cnt + 1'b1;
        end
    end

    always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n) begin
            st_q <= '0;
        end else begin
            st_q <= st_d;
        end
    end

    assign ready_o = (st_q.cnt == WAKE_C);

endmodule

// File: rtl/hb_guard.sv
module hb_guard
    import hbg_pkg::*;
#(
    parameter int NBR      = 2,
    parameter int OC_QUAL  = 175,
    parameter int WAKE_CYC = 50000
) (
    input  logic           clk,
    input  logic           rst_n,
    input  logic           sleep_n,
    input  logic           uv_flag,
    input  logic           ot_flag,
    input  logic [NBR-1:0] oc_flag,
    output logic [NBR-1:0] bridge_en,
    output logic           fault_n,
    output logic           logic_rst,
    output logic           ready
);
    typedef struct packed {
        logic ot;
    } top_st_t;

    hbg_mode_e      mode;
    logic [NBR-1:0] trip;
    logic           wake_done;
    top_st_t        st_d, st_q;

    always_comb begin
        if (uv_flag) begin
            mode = MODE_HOLD;
        end else if (!sleep_n) begin
            mode = MODE_SLEEP;
        end else begin
            mode = MODE_ACTIVE;
        end
    end

    generate
        for (genvar gi = 0; gi < NBR; gi++) begin : g_bridge
            hbg_oc_qual #(.OC_QUAL(OC_QUAL)) u_qual (
                .clk     (clk),
                .rst_n   (rst_n),
                .mode    (mode),
                .oc_flag (oc_flag[gi]),
                .tripped (trip[gi])
            );
        end
    endgenerate

    hbg_wake_timer #(.WAKE_CYC(WAKE_CYC)) u_wake (
        .clk     (clk),
        .rst_n   (rst_n),
        .mode    (mode),
        .ready_o (wake_done)
    );

    always_comb begin
        st_d    = st_q;
        st_d.ot = (mode == MODE_ACTIVE) && ot_flag;
    end

    always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n) begin
            st_q <= '0;
        end else begin
            st_q <= st_d;
        end
    end

    assign ready     = wake_done;
    assign logic_rst = !rst_n || uv_flag;
    assign fault_n   = !((|trip) || st_q.ot);
    assign bridge_en = {NBR{wake_done && !st_q.ot}} & ~trip;

endmodule

// File: rtl/hbg_guard_chk.sv
module hbg_guard_chk #(
    parameter int NBR = 2
) (
    input logic           clk,
    input logic           rst_n,
    input logic           sleep_n,
    input logic           uv_flag,
    input logic           ot_flag,
    input logic [NBR-1:0] bridge_en,
    input logic           fault_n,
    input logic           ready
);
    AST_UV_CLEARS: assert property (@(posedge clk) disable iff (!rst_n)
        uv_flag |=> (fault_n && !ready && bridge_en == '0)); // R5

    AST_SLEEP_OFF: assert property (@(posedge clk) disable iff (!rst_n)
        (!sleep_n && !uv_flag) |=> (!ready && bridge_en == '0)); // R6

    AST_EN_NEEDS_READY: assert property (@(posedge clk) disable iff (!rst_n)
        (bridge_en != '0) |-> ready); // R8

    AST_READY_AFTER_WAKE: assert property (@(posedge clk) disable iff (!rst_n)
        $rose(ready) |-> ($past(sleep_n) && !$past(uv_flag))); // R7

    AST_OT_FAULT: assert property (@(posedge clk) disable iff (!rst_n)
        (sleep_n && !uv_flag && ot_flag) |=> (!fault_n && bridge_en == '0)); // R4

    AST_FAULT_BLOCKS_BOTH: assert property (@(posedge clk) disable iff (!rst_n)
        (!fault_n && ready) |-> (bridge_en != {NBR{1'b1}})); // R9
endmodule

bind hb_guard hbg_guard_chk #(.NBR(NBR)) u_guard_chk (
    .clk       (clk),
    .rst_n     (rst_n),
    .sleep_n   (sleep_n),
    .uv_flag   (uv_flag),
    .ot_flag   (ot_flag),
    .bridge_en (bridge_en),
    .fault_n   (fault_n),
    .ready     (ready)
);

// File: tb/hb_guard_bench.sv
module hb_guard_bench;
    localparam int NBR  = 2;
    localparam int QUAL = 4;
    localparam int WAKE = 20;

    logic           clk = 1'b0;
    logic           rst_n = 1'b0;
    logic           sleep_n = 1'b1;
    logic           uv_flag = 1'b0;
    logic           ot_flag = 1'b0;
    logic [NBR-1:0] oc_flag = '0;
    logic [NBR-1:0] bridge_en;
    logic           fault_n, logic_rst, ready;

    int n_chk = 0;
    int n_bad = 0;
    bit done = 1'b0;

    always #2.5 clk = ~clk;

    hb_guard #(.NBR(NBR), .OC_QUAL(QUAL), .WAKE_CYC(WAKE)) u_hb_guard (
        .clk(clk), .rst_n(rst_n), .sleep_n(sleep_n), .uv_flag(uv_flag),
        .ot_flag(ot_flag), .oc_flag(oc_flag), .bridge_en(bridge_en),
        .fault_n(fault_n), .logic_rst(logic_rst), .ready(ready)
    );

    task automatic step(input int n);
        repeat (n) @(negedge clk);
    endtask

    task automatic chk(input string req, input int act, input int exp);
        n_chk++;
        if (act != exp) begin
            n_bad++;
            $display("FAIL %s: actual %0d expected %0d", req, act, exp);
        end
    endtask

    task automatic rearm();
        rst_n = 1'b0;
        step(1);
        chk("R1 fault_n in reset", int'(fault_n), 1);
        rst_n = 1'b1;
        step(WAKE);
        chk("R7 ready after re-arm", int'(ready), 1);
    endtask

    initial begin
        step(3);
        chk("R1 logic_rst", int'(logic_rst), 1);
        chk("R1 ready", int'(ready), 0);
        chk("R1 enables", int'(bridge_en), 0);
        chk("R1 fault_n", int'(fault_n), 1);

        rst_n = 1'b1;
        step(WAKE - 1);
        chk("R7 ready before delay", int'(ready), 0);
        chk("R1 logic_rst released", int'(logic_rst), 0);
        step(1);
        chk("R7 ready at delay", int'(ready), 1);
        chk("R8 both enabled", int'(bridge_en), 3);
        chk("R9 no fault", int'(fault_n), 1);

        // R2 / R3 sweep of pulse lengths on each bridge
        for (int b = 0; b < NBR; b++) begin
            for (int len = 1; len <= QUAL + 2; len++) begin
                oc_flag[b] = 1'b1;
                step(len);
                oc_flag[b] = 1'b0;
                step(1);
                chk($sformatf("R2 fault_n b%0d len%0d", b, len), int'(fault_n),
                    (len > QUAL) ? 0 : 1);
                chk($sformatf("R3 en b%0d len%0d", b, len), int'(bridge_en[b]),
                    (len > QUAL) ? 0 : 1);
                chk($sformatf("R3 other bridge b%0d len%0d", b, len),
                    int'(bridge_en[1-b]), 1);
                if (len > QUAL) begin
                    step(5);
                    chk("R3 latch persists", int'(fault_n), 0);
                    rearm();
                    chk("R3 cleared by reset", int'(bridge_en), 3);
                end
            end
        end

        // R2 back-to-back pulses with a one-cycle gap
        oc_flag[0] = 1'b1; step(QUAL); oc_flag[0] = 1'b0; step(1);
        oc_flag[0] = 1'b1; step(QUAL); oc_flag[0] = 1'b0; step(1);
        chk("R2 gap restarts count", int'(fault_n), 1);

        // R4 over-temperature
        ot_flag = 1'b1;
        step(1);
        chk("R4 fault_n on OT", int'(fault_n), 0);
        chk("R4 enables off on OT", int'(bridge_en), 0);
        chk("R8 ready kept on OT", int'(ready), 1);
        ot_flag = 1'b0;
        step(1);
        chk("R4 auto recover fault_n", int'(fault_n), 1);
        chk("R4 auto recover enables", int'(bridge_en), 3);

        // R5 undervoltage over a live latch
        oc_flag[1] = 1'b1;
        step(QUAL + 1);
        oc_flag[1] = 1'b0;
        chk("R3 latch before UV", int'(fault_n), 0);
        uv_flag = 1'b1;
        #1;
        chk("R5 logic_rst immediate", int'(logic_rst), 1);
        step(1);
        chk("R5 latch cleared", int'(fault_n), 1);
        chk("R5 ready low", int'(ready), 0);
        chk("R5 enables off", int'(bridge_en), 0);
        uv_flag = 1'b0;
        step(WAKE - 1);
        chk("R7 ready before delay after UV", int'(ready), 0);
        step(1);
        chk("R7 ready after UV", int'(ready), 1);
        chk("R8 enables after UV", int'(bridge_en), 3);

        // R6 sleep ignores inputs
        sleep_n = 1'b0; oc_flag = 2'b11; ot_flag = 1'b1;
        step(QUAL + 3);
        chk("R6 ready in sleep", int'(ready), 0);
        chk("R6 enables in sleep", int'(bridge_en), 0);
        chk("R6 flags ignored", int'(fault_n), 1);
        sleep_n = 1'b1; oc_flag = '0; ot_flag = 1'b0;
        step(WAKE);
        chk("R6 no latch after sleep", int'(fault_n), 1);
        chk("R7 ready after sleep", int'(ready), 1);

        // R6 frozen count resumes after wake
        oc_flag[0] = 1'b1;
        step(QUAL);
        chk("R2 not yet latched", int'(fault_n), 1);
        sleep_n = 1'b0;
        step(3);
        chk("R6 frozen, no latch", int'(fault_n), 1);
        sleep_n = 1'b1;
        step(1);
        oc_flag[0] = 1'b0;
        chk("R6 resumed count latches", int'(fault_n), 0);
        step(WAKE);
        chk("R8 tripped bridge off", int'(bridge_en), 2);
        rearm();
        chk("R9 clear after reset", int'(fault_n), 1);

        done = 1'b1;
    end

    initial begin
        for (int i = 0; i < 20000; i++) begin
            if (done) break;
            @(posedge clk);
        end
        if (!done) begin
            n_chk++;
            n_bad++;
            $display("FAIL watchdog: actual 0 expected 1 (run did not complete)");
        end
        $display("*** SUMMARY: %0d compared / %0d mismatched ***", n_chk, n_bad);
        $finish;
    end
endmodule